// File: doc/BRIEF.md
# Accumulator ALU with Packed Status Flags

This block is an 8-bit arithmetic and logic unit built around an accumulator register and a five-flag status register. Each cycle a caller may either load the accumulator with a value (a pure data move) or issue one operation chosen by a 4-bit code. The accumulator is always the first operand. Operations that take a second operand read it from a separate input. The result goes back into the accumulator.

The flags describe the most recent arithmetic, logic or shift result. They are sign, zero, nibble carry, even parity and carry. They can be read at any time as one packed byte with fixed bit positions. A data load leaves the flags untouched, so the flags from a computation survive the moves that follow it. The operation set covers addition and subtraction, each with or without the stored carry. It also covers bitwise AND, OR, XOR and complement, four rotates and two logical shifts. Codes 14 and 15 are reserved and do nothing.

Top module: `alu_flags_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the accumulator reads 0x00 and the flag byte reads 0x00.
- R2: When load_en is high at a clock edge, the accumulator takes load_data on that edge and the flag byte keeps its value. load_en takes priority over op_valid, so an operation issued in the same cycle is discarded.
- R3: The flag byte holds sign at bit 7, zero at bit 6, nibble carry at bit 4, parity at bit 2 and carry at bit 0. Bits 5, 3 and 1 always read 0.
- R4: After each operation with code 0 to 7, 12 or 13, sign equals bit 7 of the new accumulator. Zero is set exactly when the new accumulator is 0x00. Parity is set exactly when the new accumulator has an even number of ones.
- R5: Code 0 adds the operand to the accumulator, and code 1 also adds the stored carry. Carry is set on a carry out of bit 7. Nibble carry is set on a carry from bit 3 into bit 4.
- R6: Code 2 subtracts the operand from the accumulator, and code 3 also subtracts the stored carry. Carry is set when the operand, plus the stored carry for code 3, exceeds the unsigned accumulator. Nibble carry is set on a borrow into the low nibble.
- R7: Codes 4, 5 and 6 give AND, OR and XOR of the accumulator and the operand, and all three clear carry. Nibble carry is set by AND and cleared by OR and XOR.
- R8: Code 7 complements the accumulator and leaves carry and nibble carry unchanged.
- R9: Code 8 rotates left and code 9 rotates right. Code 10 rotates left through carry and code 11 rotates right through carry. Each puts the bit shifted out into carry and leaves sign, zero, nibble carry and parity unchanged.
- R10: Code 12 shifts left and code 13 shifts right, filling with zero. Each puts the bit shifted out into carry and clears nibble carry.
- R11: Codes 14 and 15, and any cycle with op_valid and load_en both low, change neither the accumulator nor the flag byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_en | input | 1 | Load the accumulator from load_data |
| load_data | input | 8 | Value to load |
| op_valid | input | 1 | Execute op_code this cycle |
| op_code | input | 4 | Operation select |
| operand_b | input | 8 | Second operand for the add, subtract and bitwise operations |
| acc_out | output | 8 | Accumulator contents |
| flags_out | output | 8 | Packed flag byte |

## Verification
The hardest state to reach from the ports is a known stored carry ahead of the carry-consuming operations, such as add with carry, subtract with borrow and the rotates through carry. No port writes the flags directly. Before each vector the stimulus therefore shifts a chosen bit out of a known accumulator value, which leaves carry at 0 or 1 with zero and parity set. It then loads the real operand, and because a load does not alter the flags, that carry is still in place. Borrow across the nibble boundary and all-ones results reached with a stored carry are covered the same way.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int OP_W   = 4;

  localparam int FLG_S  = 7;
  localparam int FLG_Z  = 6;
  localparam int FLG_AC = 4;
  localparam int FLG_P  = 2;
  localparam int FLG_CY = 0;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOT  = 4'd7,
    OP_ROL  = 4'd8,
    OP_ROR  = 4'd9,
    OP_RCL  = 4'd10,
    OP_RCR  = 4'd11,
    OP_SHL  = 4'd12,
    OP_SHR  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flag_set_t;

  function automatic logic [DATA_W-1:0] pack_flags(input flag_set_t f);
    logic [DATA_W-1:0] v;
    v         = '0;
    v[FLG_S]  = f.s;
    v[FLG_Z]  = f.z;
    v[FLG_AC] = f.ac;
    v[FLG_P]  = f.p;
    v[FLG_CY] = f.cy;
    return v;
  endfunction
endpackage

// File: rtl/alu_adder.sv
module alu_adder
  import alu_flags_pkg::*;
(
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic              use_cy,
  input  logic              cy_in,
  output logic [DATA_W-1:0] sum,
  output logic              cy_out,
  output logic              nib_out
);
  logic [DATA_W-1:0] b_eff;
  logic              cin;
  logic [DATA_W:0]   full;
  logic [NIB_W:0]    low;

  // Subtraction is a + ~b + 1 (or + ~cy with borrow); carries invert to borrows.
  always_comb begin
    b_eff   = sub ? ~b : b;
    cin     = sub ^ (use_cy & cy_in);
    full    = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
    low     = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
    sum     = full[DATA_W-1:0];
    cy_out  = full[DATA_W] ^ sub;
    nib_out = low[NIB_W] ^ sub;
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_flags_pkg::*;
(
  input  op_e               op,
  input  logic [DATA_W-1:0] a,
  input  logic              cy_in,
  output logic [DATA_W-1:0] res,
  output logic              cy_out
);
  always_comb begin
    res    = a;
    cy_out = cy_in;
    unique case (op)
      OP_ROL: begin res = {a[DATA_W-2:0], a[DATA_W-1]}; cy_out = a[DATA_W-1]; end
      OP_ROR: begin res = {a[0], a[DATA_W-1:1]};        cy_out = a[0];        end
      OP_RCL: begin res = {a[DATA_W-2:0], cy_in};       cy_out = a[DATA_W-1]; end
      OP_RCR: begin res = {cy_in, a[DATA_W-1:1]};       cy_out = a[0];        end
      OP_SHL: begin res = {a[DATA_W-2:0], 1'b0};        cy_out = a[DATA_W-1]; end
      OP_SHR: begin res = {1'b0, a[DATA_W-1:1]};        cy_out = a[0];        end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_exec_unit.sv
module alu_exec_unit
  import alu_flags_pkg::*;
(
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  input  flag_set_t         flags,
  output logic [DATA_W-1:0] res,
  output logic              wr_acc,
  output flag_set_t         new_f,
  output flag_set_t         upd_mask
);
  op_e               op;
  logic              is_sub;
  logic              is_carry_op;
  logic [DATA_W-1:0] add_sum;
  logic              add_cy;
  logic              add_nib;
  logic [DATA_W-1:0] sh_res;
  logic              sh_cy;

  assign op          = op_e'(op_code);
  assign is_sub      = (op == OP_SUB) || (op == OP_SBB);
  assign is_carry_op = (op == OP_ADC) || (op == OP_SBB);

  alu_adder u_add (
    .a       (acc),
    .b       (opnd),
    .sub     (is_sub),
    .use_cy  (is_carry_op),
    .cy_in   (flags.cy),
    .sum     (add_sum),
    .cy_out  (add_cy),
    .nib_out (add_nib)
  );

  alu_shifter u_shf (
    .op     (op),
    .a      (acc),
    .cy_in  (flags.cy),
    .res    (sh_res),
    .cy_out (sh_cy)
  );

  localparam flag_set_t ALL_F  = '{s: 1'b1, z: 1'b1, ac: 1'b1, p: 1'b1, cy: 1'b1};
  localparam flag_set_t SZP_F  = '{s: 1'b1, z: 1'b1, ac: 1'b0, p: 1'b1, cy: 1'b0};
  localparam flag_set_t CY_F   = '{s: 1'b0, z: 1'b0, ac: 1'b0, p: 1'b0, cy: 1'b1};

  always_comb begin
    res      = acc;
    wr_acc   = 1'b1;
    upd_mask = '0;
    new_f    = flags;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        res = add_sum; new_f.cy = add_cy; new_f.ac = add_nib; upd_mask = ALL_F;
      end
      OP_AND: begin res = acc & opnd; new_f.cy = 1'b0; new_f.ac = 1'b1; upd_mask = ALL_F; end
      OP_OR:  begin res = acc | opnd; new_f.cy = 1'b0; new_f.ac = 1'b0; upd_mask = ALL_F; end
      OP_XOR: begin res = acc ^ opnd; new_f.cy = 1'b0; new_f.ac = 1'b0; upd_mask = ALL_F; end
      OP_NOT: begin res = ~acc; upd_mask = SZP_F; end
      OP_ROL, OP_ROR, OP_RCL, OP_RCR: begin
        res = sh_res; new_f.cy = sh_cy; upd_mask = CY_F;
      end
      OP_SHL, OP_SHR: begin
        res = sh_res; new_f.cy = sh_cy; new_f.ac = 1'b0; upd_mask = ALL_F;
      end
      default: wr_acc = 1'b0;
    endcase
    new_f.s = res[DATA_W-1];
    new_f.z = ~|res;
    new_f.p = ~^res;
  end
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
  import alu_flags_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  flag_set_t         upd_mask,
  input  flag_set_t         new_f,
  output flag_set_t         flags_q,
  output logic [DATA_W-1:0] flag_byte
);
  flag_set_t flags_d;

  always_comb begin
    flags_d = flags_q;
    if (en) flags_d = (flags_q & ~upd_mask) | (new_f & upd_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flag_byte = pack_flags(flags_q);

  // Unused positions in the packed byte never carry a one.
  p_unused_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_byte[5] == 1'b0) && (flag_byte[3] == 1'b0) && (flag_byte[1] == 1'b0));

  // A flag outside the update mask holds across an enabled write.
  p_mask_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !upd_mask.s && !upd_mask.z && !upd_mask.p && !upd_mask.ac) |=>
      ($stable(flags_q.s) && $stable(flags_q.z) && $stable(flags_q.p) && $stable(flags_q.ac)));
endmodule

// File: rtl/alu_acc_reg.sv
module alu_acc_reg
  import alu_flags_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_next;

  always_comb q_next = en ? d : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_flags_pkg::*;
#(
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_data,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] operand_b,
  output logic [DATA_W-1:0] acc_out,
  output logic [DATA_W-1:0] flags_out
);
  logic [RST_SYNC_STAGES-1:0] rst_pipe;
  logic                       rst_int_n;

  generate
    if (RST_SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= {rst_pipe[RST_SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate
  assign rst_int_n = rst_pipe[RST_SYNC_STAGES-1];

  logic [DATA_W-1:0] acc_q;
  flag_set_t         flags_q;
  logic [DATA_W-1:0] ex_res;
  logic              ex_wr;
  flag_set_t         ex_flags;
  flag_set_t         ex_mask;
  logic              exec_go;
  logic              acc_en;
  logic [DATA_W-1:0] acc_d;

  alu_exec_unit u_exec (
    .op_code  (op_code),
    .acc      (acc_q),
    .opnd     (operand_b),
    .flags    (flags_q),
    .res      (ex_res),
    .wr_acc   (ex_wr),
    .new_f    (ex_flags),
    .upd_mask (ex_mask)
  );

  // Load wins over an operation in the same cycle.
  always_comb begin
    exec_go = op_valid && !load_en;
    acc_en  = load_en || (exec_go && ex_wr);
    acc_d   = load_en ? load_data : ex_res;
  end

  alu_acc_reg u_acc (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (acc_en),
    .d     (acc_d),
    .q     (acc_q)
  );

  alu_status_reg u_flg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en        (exec_go),
    .upd_mask  (ex_mask),
    .new_f     (ex_flags),
    .flags_q   (flags_q),
    .flag_byte (flags_out)
  );

  assign acc_out = acc_q;

  logic is_rot, is_logic, is_szp, is_rsv;
  always_comb begin
    is_rot   = (op_code >= 4'd8) && (op_code <= 4'd11);
    is_logic = (op_code >= 4'd4) && (op_code <= 4'd6);
    is_rsv   = (op_code >= 4'd14);
    is_szp   = !is_rot && !is_rsv;
  end

  p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    load_en |=> (acc_out == $past(load_data)));

  p_load_keeps_flags_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    load_en |=> $stable(flags_out));

  p_idle_no_change_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!load_en && (!op_valid || is_rsv)) |=> ($stable(acc_out) && $stable(flags_out)));

  p_rotate_keeps_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && !load_en && is_rot) |=>
      ($stable(flags_out[FLG_S]) && $stable(flags_out[FLG_Z]) &&
       $stable(flags_out[FLG_P]) && $stable(flags_out[FLG_AC])));

  p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && !load_en && is_szp) |=> (flags_out[FLG_Z] == (acc_out == '0)));

  p_parity_flag_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && !load_en && is_szp) |=> (flags_out[FLG_P] == ~^acc_out));

  p_sign_flag_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && !load_en && is_szp) |=> (flags_out[FLG_S] == acc_out[DATA_W-1]));

  p_logic_clears_cy_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && !load_en && is_logic) |=> (flags_out[FLG_CY] == 1'b0));
endmodule

// File: tb/sim_alu_flags_unit.sv
`timescale 1ns/1ps
module sim_alu_flags_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       load_en;
  logic [7:0] load_data;
  logic       op_valid;
  logic [3:0] op_code;
  logic [7:0] operand_b;
  logic [7:0] acc_out;
  logic [7:0] flags_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  alu_flags_unit u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_data (load_data),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .operand_b (operand_b),
    .acc_out   (acc_out),
    .flags_out (flags_out)
  );

  // {carry before, accumulator, code, operand, expected acc, expected flags}
  localparam int NV = 20;
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 8'h3A, 4'd0,  8'hC6, 8'h00, 8'h55},
    {1'b0, 8'h14, 4'd0,  8'h22, 8'h36, 8'h04},
    {1'b1, 8'h0F, 4'd1,  8'h00, 8'h10, 8'h10},
    {1'b1, 8'hFF, 4'd1,  8'hFF, 8'hFF, 8'h95},
    {1'b0, 8'h05, 4'd2,  8'h07, 8'hFE, 8'h91},
    {1'b1, 8'h40, 4'd2,  8'h40, 8'h00, 8'h44},
    {1'b1, 8'h40, 4'd3,  8'h3F, 8'h00, 8'h54},
    {1'b1, 8'h10, 4'd3,  8'h10, 8'hFF, 8'h95},
    {1'b1, 8'hF0, 4'd4,  8'h3C, 8'h30, 8'h14},
    {1'b1, 8'h80, 4'd5,  8'h01, 8'h81, 8'h84},
    {1'b1, 8'hAA, 4'd6,  8'hAA, 8'h00, 8'h44},
    {1'b1, 8'h0F, 4'd7,  8'hEE, 8'hF0, 8'h85},
    {1'b0, 8'h81, 4'd8,  8'hEE, 8'h03, 8'h45},
    {1'b1, 8'h02, 4'd9,  8'hEE, 8'h01, 8'h44},
    {1'b1, 8'h40, 4'd10, 8'hEE, 8'h81, 8'h44},
    {1'b1, 8'h01, 4'd11, 8'hEE, 8'h80, 8'h45},
    {1'b0, 8'hC1, 4'd12, 8'hEE, 8'h82, 8'h85},
    {1'b1, 8'h02, 4'd13, 8'hEE, 8'h01, 8'h00},
    {1'b1, 8'h5A, 4'd14, 8'h11, 8'h5A, 8'h45},
    {1'b0, 8'h00, 4'd15, 8'h11, 8'h00, 8'h44}
  };

  function automatic string tag_of(input logic [3:0] op);
    if (op <= 4'd1)       return "R5";
    else if (op <= 4'd3)  return "R6";
    else if (op <= 4'd6)  return "R7";
    else if (op == 4'd7)  return "R8";
    else if (op <= 4'd11) return "R9";
    else if (op <= 4'd13) return "R10";
    else                  return "R11";
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  // Inputs change on the falling edge; results are read one falling edge later.
  task automatic step(input logic ld, input logic [7:0] ld_d, input logic v,
                      input logic [3:0] op, input logic [7:0] b);
    @(negedge clk);
    load_en = ld; load_data = ld_d; op_valid = v; op_code = op; operand_b = b;
    @(negedge clk);
    load_en = 1'b0; op_valid = 1'b0;
  endtask

  // Leaves carry = c with zero and parity set (flags 0x44 or 0x45).
  task automatic preset_carry(input logic c);
    if (c) begin step(1'b1, 8'h80, 1'b0, 4'd0, 8'h00); step(1'b0, 8'h00, 1'b1, 4'd12, 8'h00); end
    else   begin step(1'b1, 8'h00, 1'b0, 4'd0, 8'h00); step(1'b0, 8'h00, 1'b1, 4'd13, 8'h00); end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "acc in reset", acc_out, 8'h00);
    check("R1", "flags in reset", flags_out, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; load_en = 1'b0; load_data = '0; op_valid = 1'b0; op_code = '0; operand_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "acc after reset", acc_out, 8'h00);
    check("R1", "flags after reset", flags_out, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic       c;
      logic [7:0] a, b, ea, ef;
      logic [3:0] op;
      {c, a, op, b, ea, ef} = VEC[i];
      preset_carry(c);
      step(1'b1, a, 1'b0, 4'd0, 8'h00);
      check("R2", "flags kept by load", flags_out, {7'h22, c});
      step(1'b0, 8'h00, 1'b1, op, b);
      check(tag_of(op), $sformatf("acc op=%0d", op), acc_out, ea);
      check(tag_of(op), $sformatf("flags op=%0d", op), flags_out, ef);
      check("R3", "unused flag bits", flags_out & 8'h2A, 8'h00);
      check("R4", "zero/sign/parity consistency",
            (op >= 4'd8 && op <= 4'd11) || op >= 4'd14 ? 8'h00 :
            ((flags_out & 8'hC4) ^ {acc_out[7], acc_out == 8'h00, 3'b000, ~^acc_out, 2'b00}),
            8'h00);
    end

    // R2: load and operation together; the load wins and flags hold.
    preset_carry(1'b1);
    step(1'b1, 8'h7E, 1'b1, 4'd0, 8'h01);
    check("R2", "acc on load+op", acc_out, 8'h7E);
    check("R2", "flags on load+op", flags_out, 8'h45);

    // R11: an operation code presented without op_valid is ignored.
    step(1'b0, 8'h00, 1'b0, 4'd0, 8'h01);
    check("R11", "acc with op_valid low", acc_out, 8'h7E);
    check("R11", "flags with op_valid low", flags_out, 8'h45);

    // R6: zero minus one with borrow gives all ones and a borrow.
    step(1'b1, 8'h00, 1'b0, 4'd0, 8'h00);
    step(1'b0, 8'h00, 1'b1, 4'd3, 8'h00);
    check("R6", "acc 00-00-cy", acc_out, 8'hFF);
    check("R6", "flags 00-00-cy", flags_out, 8'h95);

    // R1: reset in the middle of operation.
    do_reset();
    check("R1", "acc after second reset", acc_out, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired before the bench finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule